// File: doc/BRIEF.md
# Gate On-Time and Current-Limit Controller

This block owns the power switch gate of a quasi-resonant LED converter for the span of one switching cycle. A start pulse from the valley or restart logic turns the gate on. While the gate is on, three events can end the cycle: the constant-on-time comparator, the cycle-by-cycle current-limit comparator, and a hard maximum-on clamp. The constant-on-time comparator cannot cut the pulse below a minimum width. The current-limit flag is masked during a leading-edge blanking interval after turn-on. A forced-off input overrides everything else.

Every turn-off produces a one-clock done pulse and a cause code. It also opens a blanking window that the downstream valley and overvoltage samplers use to ignore ringing. The window length is a fixed base plus a term proportional to the peak sense voltage. That voltage arrives as an 8-bit code at 10 mV per step, and the window length in clock cycles is worked out at the moment of turn-off. With the default 50 MHz clock, the window is 2 µs plus 2 µs per volt. All durations are parameters in clock cycles.

Top module: `gate_ontime_ctrl`

## Requirements
- R1: When the on-time comparator flag is seen during a gate pulse, the gate turns off no earlier than TON_MIN_CYC cycles after it rose. A trip seen before that point is remembered and ends the pulse at exactly TON_MIN_CYC cycles. A later trip ends it in the cycle the flag is sampled.
- R2: No gate pulse lasts longer than TON_MAX_CYC cycles. When that count is reached, the gate is forced low with cause code 2'b11.
- R3: A current-limit flag sampled while fewer than LEB_CYC cycles of the pulse have elapsed has no effect on the gate.
- R4: A current-limit flag sampled once LEB_CYC or more cycles of the pulse have elapsed drops the gate at that clock edge, with cause code 2'b10. This holds even before TON_MIN_CYC is reached.
- R5: The disable input drops the gate at the next clock edge with cause code 2'b00, ahead of every other condition. A start pulse is not accepted while disable is high.
- R6: At every turn-off, done_o is high for exactly one cycle, in the first cycle the gate is low. The cause code is valid with it: 2'b00 forced, 2'b01 comparator, 2'b10 current limit, 2'b11 maximum on. When several conditions coincide, the priority is forced, then maximum on, then current limit, then comparator.
- R7: blank_o goes high in the first cycle the gate is low. It stays high for BLANK_BASE_CYC + BLANK_PER_LSB_CYC × code cycles, where code is the peak sense value sampled at the turn-off edge.
- R8: A start pulse that arrives while the gate is on does not restart or extend the pulse.
- R9: After reset, gate_o, done_o and blank_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Turn-on request pulse |
| disable_i | input | 1 | Forced-off request |
| cot_trip_i | input | 1 | On-time comparator flag |
| ilim_trip_i | input | 1 | Current-limit comparator flag |
| cs_peak_i | input | CODE_W | Peak sense voltage code, 10 mV per step |
| gate_o | output | 1 | Gate drive command |
| done_o | output | 1 | One-cycle turn-off pulse |
| cause_o | output | 2 | Turn-off cause code |
| blank_o | output | 1 | Post-turn-off sampling blank window |

## Verification
The bench builds the block with TON_MIN_CYC=8, TON_MAX_CYC=40, LEB_CYC=3, BLANK_BASE_CYC=5 and BLANK_PER_LSB_CYC=1. With these values a maximum-on pulse ends within forty cycles, so the clamp, the blanking edge and the minimum floor can each be reached one cycle either side. A current-limit trip that lands inside the minimum-on window can also be placed so that it beats the comparator floor. The full 8-bit code range of the blank window is exercised, up to 260 cycles.

// File: rtl/goc_pkg.sv
package goc_pkg;
  typedef enum logic [1:0] {
    CAUSE_FORCED = 2'b00,
    CAUSE_COT    = 2'b01,
    CAUSE_ILIM   = 2'b10,
    CAUSE_MAX    = 2'b11
  } end_cause_e;
endpackage

// File: rtl/goc_on_timer.sv
module goc_on_timer
  import goc_pkg::*;
#(
  parameter int TON_MIN_CYC = 62,
  parameter int TON_MAX_CYC = 2350,
  parameter int LEB_CYC     = 20,
  parameter int CNT_W       = $clog2(TON_MAX_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             turn_on_i,
  input  logic             cot_trip_i,
  input  logic             ilim_trip_i,
  input  logic             force_off_i,
  output logic             end_req_o,
  output end_cause_e       cause_o,
  output logic [CNT_W-1:0] on_cnt_o
);
  localparam logic [CNT_W-1:0] MaxLast = CNT_W'(TON_MAX_CYC - 1);
  localparam logic [CNT_W-1:0] MinLast = CNT_W'(TON_MIN_CYC - 1);
  localparam logic [CNT_W-1:0] LebEnd  = CNT_W'(LEB_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             cot_seen_q;
  logic             max_hit, ilim_hit, cot_hit;

  assign max_hit  = cnt_q == MaxLast;
  assign ilim_hit = ilim_trip_i && (cnt_q >= LebEnd);
  // early comparator trips are held until the minimum on-time has elapsed
  assign cot_hit  = (cot_trip_i || cot_seen_q) && (cnt_q >= MinLast);

  assign end_req_o = gate_i && (force_off_i || max_hit || ilim_hit || cot_hit);
  assign on_cnt_o  = cnt_q;

  always_comb begin
    if (force_off_i)   cause_o = CAUSE_FORCED;
    else if (max_hit)  cause_o = CAUSE_MAX;
    else if (ilim_hit) cause_o = CAUSE_ILIM;
    else               cause_o = CAUSE_COT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      cot_seen_q <= 1'b0;
    end else if (turn_on_i) begin
      cnt_q      <= '0;
      cot_seen_q <= 1'b0;
    end else if (gate_i) begin
      if (!max_hit) cnt_q <= cnt_q + 1'b1;
      if (cot_trip_i) cot_seen_q <= 1'b1;
    end
  end

  p_max_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i |-> on_cnt_o <= MaxLast);

  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(gate_i) && gate_i) |-> on_cnt_o == CNT_W'($past(on_cnt_o) + 1'b1));
endmodule

// File: rtl/goc_blank_timer.sv
module goc_blank_timer #(
  parameter int CODE_W            = 8,
  parameter int BLANK_BASE_CYC    = 100,
  parameter int BLANK_PER_LSB_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              blank_o
);
  localparam int BlankMax = BLANK_BASE_CYC + BLANK_PER_LSB_CYC * ((1 << CODE_W) - 1);
  localparam int BL_W     = $clog2(BlankMax + 1);

  logic [BL_W-1:0] len;
  logic [BL_W-1:0] cnt_q;

  generate
    if (BLANK_PER_LSB_CYC == 1) begin : g_unit_slope
      assign len = BL_W'(BLANK_BASE_CYC) + BL_W'(code_i);
    end else begin : g_scaled_slope
      assign len = BL_W'(BLANK_BASE_CYC) + BL_W'(code_i) * BL_W'(BLANK_PER_LSB_CYC);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign blank_o = cnt_q != '0;

  p_blank_countdown_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == BL_W'($past(cnt_q) - 1'b1));
endmodule

// File: rtl/gate_ontime_ctrl.sv
module gate_ontime_ctrl
  import goc_pkg::*;
#(
  parameter int TON_MIN_CYC       = 62,
  parameter int TON_MAX_CYC       = 2350,
  parameter int LEB_CYC           = 20,
  parameter int CODE_W            = 8,
  parameter int BLANK_BASE_CYC    = 100,
  parameter int BLANK_PER_LSB_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              disable_i,
  input  logic              cot_trip_i,
  input  logic              ilim_trip_i,
  input  logic [CODE_W-1:0] cs_peak_i,
  output logic              gate_o,
  output logic              done_o,
  output logic [1:0]        cause_o,
  output logic              blank_o
);
  localparam int CNT_W = $clog2(TON_MAX_CYC + 1);

  logic             gate_q, done_q;
  end_cause_e       cause_q, cause_w;
  logic             end_req, turn_on;
  logic [CNT_W-1:0] on_cnt;

  assign turn_on = !gate_q && start_i && !disable_i;

  goc_on_timer #(
    .TON_MIN_CYC(TON_MIN_CYC), .TON_MAX_CYC(TON_MAX_CYC),
    .LEB_CYC(LEB_CYC), .CNT_W(CNT_W)
  ) u_on_timer (
    .clk_i, .rst_ni,
    .gate_i(gate_q), .turn_on_i(turn_on),
    .cot_trip_i, .ilim_trip_i, .force_off_i(disable_i),
    .end_req_o(end_req), .cause_o(cause_w), .on_cnt_o(on_cnt)
  );

  goc_blank_timer #(
    .CODE_W(CODE_W), .BLANK_BASE_CYC(BLANK_BASE_CYC),
    .BLANK_PER_LSB_CYC(BLANK_PER_LSB_CYC)
  ) u_blank_timer (
    .clk_i, .rst_ni, .load_i(end_req), .code_i(cs_peak_i), .blank_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      done_q  <= 1'b0;
      cause_q <= CAUSE_FORCED;
    end else begin
      done_q <= end_req;
      if (end_req) begin
        gate_q  <= 1'b0;
        cause_q <= cause_w;
      end else if (turn_on) begin
        gate_q  <= 1'b1;
      end
    end
  end

  assign gate_o  = gate_q;
  assign done_o  = done_q;
  assign cause_o = cause_q;

  p_min_cot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gate_o) && cause_o == CAUSE_COT) |-> $past(on_cnt) >= CNT_W'(TON_MIN_CYC - 1));

  p_leb_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gate_o) && cause_o == CAUSE_ILIM) |-> $past(on_cnt) >= CNT_W'(LEB_CYC));

  p_force_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disable_i && gate_o) |=> (!gate_o && cause_o == CAUSE_FORCED));

  p_no_start_dis_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disable_i && !gate_o) |=> !gate_o);

  p_done_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) |-> done_o);

  p_done_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!gate_o && $past(gate_o)));

  p_blank_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) |-> blank_o);
endmodule

// File: tb/sim_gate_ontime_ctrl.sv
module sim_gate_ontime_ctrl;
  localparam int MIN = 8, MAX = 40, LEB = 3, BASE = 5, SLOPE = 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, disable_i = 0, cot_trip_i = 0, ilim_trip_i = 0;
  logic [7:0] cs_peak_i = '0;
  logic gate_o, done_o, blank_o;
  logic [1:0] cause_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gate_ontime_ctrl #(
    .TON_MIN_CYC(MIN), .TON_MAX_CYC(MAX), .LEB_CYC(LEB), .CODE_W(8),
    .BLANK_BASE_CYC(BASE), .BLANK_PER_LSB_CYC(SLOPE)
  ) u0 (
    .clk_i(clk), .rst_ni, .start_i, .disable_i, .cot_trip_i, .ilim_trip_i,
    .cs_peak_i, .gate_o, .done_o, .cause_o, .blank_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one gate cycle; *_at = pulse count at which the input rises (0 = never)
  task automatic run_cycle(input int cot_at, input int ilim_at, input bit ilim_once,
                           input int dis_at, input int start_at, input int code,
                           output int len, output int cause, output int blen,
                           output int done0, output int done1);
    int n = 0, b0;
    cs_peak_i = 8'(code);
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    while (gate_o === 1'b1 && n < 200) begin
      n++;
      cot_trip_i  = (cot_at != 0) && (n >= cot_at);
      ilim_trip_i = (ilim_at != 0) && (ilim_once ? (n == ilim_at) : (n >= ilim_at));
      disable_i   = (dis_at != 0) && (n >= dis_at);
      start_i     = (n == start_at);
      @(negedge clk);
    end
    cot_trip_i = 0; ilim_trip_i = 0; disable_i = 0; start_i = 0;
    len = n; cause = cause_o; done0 = done_o; b0 = blank_o;
    @(negedge clk) done1 = done_o;
    blen = b0;
    while (blank_o === 1'b1 && blen < 1000) begin
      blen++;
      @(negedge clk);
    end
  endtask

  task automatic one(input string req, input int cot_at, input int ilim_at, input bit once,
                     input int dis_at, input int start_at, input int code,
                     input int e_len, input int e_cause, input int e_blen);
    int len, cause, blen, d0, d1;
    run_cycle(cot_at, ilim_at, once, dis_at, start_at, code, len, cause, blen, d0, d1);
    chk({req, " length"}, len, e_len);
    chk({req, " cause"}, cause, e_cause);
    chk({req, " R6 done pulse"}, d0 * 2 + d1, 2);
    if (e_blen >= 0) chk({req, " blank"}, blen, e_blen);
  endtask

  task automatic t_reset_r9();
    chk("R9 gate", gate_o, 0);
    chk("R9 done", done_o, 0);
    chk("R9 blank", blank_o, 0);
  endtask

  task automatic t_min_r1();
    one("R1 early trip", 2, 0, 0, 0, 0, 0, MIN, 1, -1);
    one("R1 late trip", 15, 0, 0, 0, 0, 0, 15, 1, -1);
  endtask

  task automatic t_max_r2();
    one("R2 clamp", 0, 0, 0, 0, 0, 0, MAX, 3, -1);
  endtask

  task automatic t_leb_r3();
    one("R3 masked pulse", 0, 2, 1, 0, 0, 0, MAX, 3, -1);
    one("R3 held past blank", 0, 2, 0, 0, 0, 0, LEB + 1, 2, -1);
  endtask

  task automatic t_ilim_r4();
    one("R4 first unmasked", 0, LEB + 1, 1, 0, 0, 0, LEB + 1, 2, -1);
    one("R4 before min", 2, 5, 0, 0, 0, 0, 5, 2, -1);
  endtask

  task automatic t_disable_r5();
    int hi = 0;
    one("R5 forced", 6, 6, 0, 6, 0, 0, 6, 0, -1);
    @(negedge clk) begin disable_i = 1; start_i = 1; end
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      hi += gate_o;
    end
    disable_i = 0; start_i = 0;
    chk("R5 start blocked", hi, 0);
    @(negedge clk);
  endtask

  task automatic t_prio_r6();
    one("R6 ilim over cot", 12, 12, 0, 0, 0, 0, 12, 2, -1);
    one("R6 max over cot", MAX, 0, 0, 0, 0, 0, MAX, 3, -1);
  endtask

  task automatic t_blank_r7();
    one("R7 code 0", 10, 0, 0, 0, 0, 0, 10, 1, BASE);
    one("R7 code 37", 10, 0, 0, 0, 0, 37, 10, 1, BASE + 37 * SLOPE);
    one("R7 code 255", 10, 0, 0, 0, 0, 255, 10, 1, BASE + 255 * SLOPE);
  endtask

  task automatic t_restart_r8();
    one("R8 start while on", 12, 0, 0, 0, 3, 0, 12, 1, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r9();
    rst_ni = 1;
    @(negedge clk);
    t_reset_r9();
    t_min_r1();
    t_max_r2();
    t_leb_r3();
    t_ilim_r4();
    t_disable_r5();
    t_prio_r6();
    t_blank_r7();
    t_restart_r8();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule